// File: doc/BRIEF.md
# Ranked Clock Reference Selector

This block decides which timing reference a network node follows. It chooses among three candidates in fixed rank: a primary, a secondary and a third, which is normally the node's internal oscillator. The node can run in external mode, where the first two candidates are the two external timing inputs. It can also run in line mode, where the first two candidates are line ports picked by two index inputs. Validity and loss of each source arrive as qualified flags; the block does not measure any clock.

The block picks the best valid reference and reports the synchronization state: free-run, acquire, locked or holdover. It pulses a one-cycle event on every change of reference and holds a loss alarm for each rank. In revertive mode it returns to the primary only after a wait-to-restore period. When it times from a line port on which loop prevention is enabled, it asks that port, and no other, to send a do-not-use quality marking. All durations count ticks of a parameterized prescaler, so a simulation can shorten minutes to a few cycles.

Top module: `ref_clock_selector`

## Requirements
- R1: While reset is asserted, `sel_ref` is 3 (the third reference), `sync_state` is 0 (free-run), and all events and do-not-use requests are 0.
- R2: In external mode (`line_mode`=0) the primary and secondary are `ext_valid[0]` and `ext_valid[1]`. In line mode they are `line_valid[ref1_port]` and `line_valid[ref2_port]`. Line ports that are not selected and the external inputs in line mode have no effect on selection or alarms.
- R3: If the selected reference becomes invalid, the highest-ranked valid reference is selected at the next clock edge. Every change of `sel_ref` to 1, 2 or 3 pulses `ev_to_pri`, `ev_to_sec` or `ev_to_third` for exactly one cycle, and at most one event is high at a time.
- R4: `alm_pri`, `alm_sec` and `alm_third` are high one cycle after the matching candidate is invalid, and they clear one cycle after it becomes valid again.
- R5: When `revertive`=1 and the primary is valid while another reference is selected, the selector switches back to the primary (pulsing `ev_to_pri`) only after the primary has stayed valid for WTR_TICKS ticks.
- R6: If the primary drops while the wait-to-restore count runs, the count restarts from zero.
- R7: When `revertive`=0, a recovered primary does not displace a valid current reference. The primary is taken again only when the current reference fails.
- R8: Each new selection enters acquire (1). It reports locked (2) once ACQ_TICKS ticks have passed, and never goes from free-run or holdover straight to locked.
- R9: If no candidate is valid, `sel_ref` becomes 3. The state becomes holdover (3) if the node had been locked for at least HOLD_TICKS ticks; otherwise it becomes free-run (0).
- R10: From free-run or holdover, the highest-ranked valid candidate is selected at the next edge once any candidate is valid, and the state enters acquire.
- R11: `dus_req[p]` is 1 only in line mode, when the primary or secondary is selected, `p` is its port index and `dus_en[p]`=1. At most one bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_mode | input | 1 | 1 selects line-port candidates, 0 selects external inputs |
| ref1_port | input | PW | Line port used as primary in line mode |
| ref2_port | input | PW | Line port used as secondary in line mode |
| ext_valid | input | 2 | Validity of the two external timing inputs |
| line_valid | input | NPORT | Validity of each line port |
| int_valid | input | 1 | Validity of the third (internal) reference |
| revertive | input | 1 | Enables return to the primary after wait-to-restore |
| dus_en | input | NPORT | Per-port loop-prevention enable |
| sel_ref | output | 2 | Selected reference: 1 primary, 2 secondary, 3 third |
| sync_state | output | 2 | 0 free-run, 1 acquire, 2 locked, 3 holdover |
| ev_to_pri | output | 1 | One-cycle pulse on a change to the primary |
| ev_to_sec | output | 1 | One-cycle pulse on a change to the secondary |
| ev_to_third | output | 1 | One-cycle pulse on a change to the third |
| alm_pri | output | 1 | Primary loss alarm |
| alm_sec | output | 1 | Secondary loss alarm |
| alm_third | output | 1 | Third reference loss alarm |
| dus_req | output | NPORT | Per-port do-not-use marking request |

## Verification
Two cases are the hardest to reach from the ports. One is holdover, which needs the node to stay locked past the qualification time before every source is pulled at once. The other is the restart of the wait-to-restore count, which needs a short primary drop in the middle of that count. The stimulus reaches both by holding the sources steady for measured numbers of cycles, derived from the tick period, and then dropping and restoring them. The restart check samples at a point where a count that did not restart would already have switched back, and a restarted count would not yet have done so.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
   typedef enum logic [1:0] {
      SY_FREE = 2'd0,
      SY_ACQ  = 2'd1,
      SY_LOCK = 2'd2,
      SY_HOLD = 2'd3
   } sync_e;

   localparam logic [1:0] REF_PRI = 2'd1;
   localparam logic [1:0] REF_SEC = 2'd2;
   localparam logic [1:0] REF_THR = 2'd3;
endpackage

// File: rtl/clksel_tick.sv
module clksel_tick #(
   parameter int TICK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (TICK_DIV == 1) begin : g_every
         assign tick = rst_n;
      end else begin : g_div
         localparam int CW = $clog2(TICK_DIV);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt <= '0;
            else if (cnt == CW'(TICK_DIV - 1)) cnt <= '0;
            else cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == CW'(TICK_DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/clksel_qualify.sv
module clksel_qualify #(
   parameter int NPORT = 4,
   localparam int PW = $clog2(NPORT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_mode,
   input  logic [PW-1:0]    ref1_port,
   input  logic [PW-1:0]    ref2_port,
   input  logic [1:0]       ext_valid,
   input  logic [NPORT-1:0] line_valid,
   input  logic             int_valid,
   output logic [2:0]       cand_ok,
   output logic [2:0]       alm
);
   logic pick1, pick2;

   always_comb begin
      pick1 = 1'b0;
      pick2 = 1'b0;
      for (int p = 0; p < NPORT; p++) begin
         if (ref1_port == PW'(p)) pick1 = line_valid[p];
         if (ref2_port == PW'(p)) pick2 = line_valid[p];
      end
   end

   assign cand_ok[0] = line_mode ? pick1 : ext_valid[0];
   assign cand_ok[1] = line_mode ? pick2 : ext_valid[1];
   assign cand_ok[2] = int_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) alm <= '0;
      else        alm <= ~cand_ok;
   end
endmodule

// File: rtl/clksel_fsm.sv
module clksel_fsm
   import clksel_pkg::*;
#(
   parameter int ACQ_TICKS  = 30,
   parameter int WTR_TICKS  = 300,
   parameter int HOLD_TICKS = 140,
   localparam int AW = $clog2(ACQ_TICKS + 1),
   localparam int WW = $clog2(WTR_TICKS + 1),
   localparam int HW = $clog2(HOLD_TICKS + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic [2:0] cand_ok,
   input  logic       revertive,
   output logic [1:0] sel,
   output sync_e      state,
   output logic [2:0] ev
);
   logic [AW-1:0] acq_cnt, n_acq;
   logic [HW-1:0] lock_cnt, n_lock;
   logic [WW-1:0] wtr_cnt;
   logic [1:0]    n_sel, best;
   sync_e         n_state;
   logic          cur_ok, any_ok, lock_q, wtr_run, wtr_done, start;

   assign any_ok = |cand_ok;
   assign best   = cand_ok[0] ? REF_PRI : (cand_ok[1] ? REF_SEC : REF_THR);
   assign lock_q = (lock_cnt == HW'(HOLD_TICKS));

   always_comb begin
      case (sel)
         REF_PRI: cur_ok = cand_ok[0];
         REF_SEC: cur_ok = cand_ok[1];
         default: cur_ok = cand_ok[2];
      endcase
   end

   // wait-to-restore: runs only while primary is healthy but not in use
   assign wtr_run  = revertive && cand_ok[0] && (sel != REF_PRI) &&
                     (state == SY_ACQ || state == SY_LOCK);
   assign wtr_done = wtr_run && (wtr_cnt == WW'(WTR_TICKS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wtr_cnt <= '0;
      else if (!wtr_run) wtr_cnt <= '0;
      else if (tick && wtr_cnt != WW'(WTR_TICKS)) wtr_cnt <= wtr_cnt + 1'b1;
   end

   always_comb begin
      n_sel   = sel;
      n_state = state;
      n_acq   = acq_cnt;
      n_lock  = lock_cnt;
      start   = 1'b0;
      if (state == SY_FREE || state == SY_HOLD) begin
         if (any_ok) begin
            n_sel = best;
            start = 1'b1;
         end
      end else if (!cur_ok) begin
         if (any_ok) begin
            n_sel = best;
            start = 1'b1;
         end else begin
            n_sel   = REF_THR;
            n_state = lock_q ? SY_HOLD : SY_FREE;
            n_acq   = '0;
            n_lock  = '0;
         end
      end else if (wtr_done) begin
         n_sel = REF_PRI;
         start = 1'b1;
      end else if (tick) begin
         if (state == SY_ACQ) begin
            if (acq_cnt == AW'(ACQ_TICKS - 1)) begin
               n_state = SY_LOCK;
               n_acq   = '0;
            end else begin
               n_acq = acq_cnt + 1'b1;
            end
         end else if (!lock_q) begin
            n_lock = lock_cnt + 1'b1;
         end
      end
      if (start) begin
         n_state = SY_ACQ;
         n_acq   = '0;
         n_lock  = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel      <= REF_THR;
         state    <= SY_FREE;
         acq_cnt  <= '0;
         lock_cnt <= '0;
         ev       <= '0;
      end else begin
         sel      <= n_sel;
         state    <= n_state;
         acq_cnt  <= n_acq;
         lock_cnt <= n_lock;
         ev[0]    <= (n_sel != sel) && (n_sel == REF_PRI);
         ev[1]    <= (n_sel != sel) && (n_sel == REF_SEC);
         ev[2]    <= (n_sel != sel) && (n_sel == REF_THR);
      end
   end
endmodule

// File: rtl/clksel_dus.sv
module clksel_dus
   import clksel_pkg::*;
#(
   parameter int NPORT = 4,
   localparam int PW = $clog2(NPORT)
) (
   input  logic             line_mode,
   input  logic [1:0]       sel,
   input  logic [PW-1:0]    ref1_port,
   input  logic [PW-1:0]    ref2_port,
   input  logic [NPORT-1:0] dus_en,
   output logic [NPORT-1:0] dus_req
);
   genvar p;
   generate
      for (p = 0; p < NPORT; p++) begin : g_port
         assign dus_req[p] = line_mode && dus_en[p] &&
            ((sel == REF_PRI && ref1_port == PW'(p)) ||
             (sel == REF_SEC && ref2_port == PW'(p)));
      end
   endgenerate
endmodule

// File: rtl/ref_clock_selector.sv
module ref_clock_selector
   import clksel_pkg::*;
#(
   parameter int NPORT      = 4,
   parameter int TICK_DIV   = 50_000_000,
   parameter int ACQ_TICKS  = 30,
   parameter int WTR_TICKS  = 300,
   parameter int HOLD_TICKS = 140,
   localparam int PW = $clog2(NPORT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_mode,
   input  logic [PW-1:0]    ref1_port,
   input  logic [PW-1:0]    ref2_port,
   input  logic [1:0]       ext_valid,
   input  logic [NPORT-1:0] line_valid,
   input  logic             int_valid,
   input  logic             revertive,
   input  logic [NPORT-1:0] dus_en,
   output logic [1:0]       sel_ref,
   output logic [1:0]       sync_state,
   output logic             ev_to_pri,
   output logic             ev_to_sec,
   output logic             ev_to_third,
   output logic             alm_pri,
   output logic             alm_sec,
   output logic             alm_third,
   output logic [NPORT-1:0] dus_req
);
   generate
      if (NPORT < 2) begin : g_bad_nport
         $error("NPORT must be at least 2");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
      if (ACQ_TICKS < 1 || WTR_TICKS < 1 || HOLD_TICKS < 1) begin : g_bad_time
         $error("timer lengths must be at least one tick");
      end
   endgenerate

   logic       tick;
   logic [2:0] cand_ok, alm, ev;
   sync_e      state;

   clksel_tick #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   clksel_qualify #(.NPORT(NPORT)) u_qual (
      .clk(clk), .rst_n(rst_n), .line_mode(line_mode),
      .ref1_port(ref1_port), .ref2_port(ref2_port),
      .ext_valid(ext_valid), .line_valid(line_valid), .int_valid(int_valid),
      .cand_ok(cand_ok), .alm(alm)
   );

   clksel_fsm #(
      .ACQ_TICKS(ACQ_TICKS), .WTR_TICKS(WTR_TICKS), .HOLD_TICKS(HOLD_TICKS)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cand_ok(cand_ok),
      .revertive(revertive), .sel(sel_ref), .state(state), .ev(ev)
   );

   clksel_dus #(.NPORT(NPORT)) u_dus (
      .line_mode(line_mode), .sel(sel_ref), .ref1_port(ref1_port),
      .ref2_port(ref2_port), .dus_en(dus_en), .dus_req(dus_req)
   );

   assign sync_state  = state;
   assign ev_to_pri   = ev[0];
   assign ev_to_sec   = ev[1];
   assign ev_to_third = ev[2];
   assign alm_pri     = alm[0];
   assign alm_sec     = alm[1];
   assign alm_third   = alm[2];
endmodule

// File: rtl/ref_clock_selector_chk.sv
module ref_clock_selector_chk #(
   parameter int NPORT = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             line_mode,
   input logic [1:0]       sel_ref,
   input logic [1:0]       sync_state,
   input logic             ev_to_pri,
   input logic             ev_to_sec,
   input logic             ev_to_third,
   input logic [NPORT-1:0] dus_req
);
   // R3
   events_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_to_pri, ev_to_sec, ev_to_third}));

   // R3
   ev_sec_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_to_sec |-> (sel_ref == 2'd2 && $past(sel_ref) != 2'd2));

   // R3
   ev_third_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_to_third |-> (sel_ref == 2'd3 && $past(sel_ref) != 2'd3));

   // R8
   lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_state == 2'd2 && $past(sync_state) != 2'd2) |-> $past(sync_state) == 2'd1);

   // R9
   hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_state == 2'd3 && $past(sync_state) != 2'd3) |-> $past(sync_state) == 2'd2);

   // R9
   hold_on_third_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_state == 2'd3 || sync_state == 2'd0) |-> sel_ref == 2'd3);

   // R11
   dus_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dus_req));

   // R11
   dus_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|dus_req) |-> (line_mode && sel_ref != 2'd3));
endmodule

bind ref_clock_selector ref_clock_selector_chk #(.NPORT(NPORT)) u_chk (
   .clk(clk), .rst_n(rst_n), .line_mode(line_mode), .sel_ref(sel_ref),
   .sync_state(sync_state), .ev_to_pri(ev_to_pri), .ev_to_sec(ev_to_sec),
   .ev_to_third(ev_to_third), .dus_req(dus_req)
);

// File: tb/sim_ref_clock_selector.sv
module sim_ref_clock_selector;
   localparam int NPORT = 4;
   localparam int PW    = 2;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             line_mode;
   logic [PW-1:0]    ref1_port, ref2_port;
   logic [1:0]       ext_valid;
   logic [NPORT-1:0] line_valid;
   logic             int_valid;
   logic             revertive;
   logic [NPORT-1:0] dus_en;
   logic [1:0]       sel_ref, sync_state;
   logic             ev_to_pri, ev_to_sec, ev_to_third;
   logic             alm_pri, alm_sec, alm_third;
   logic [NPORT-1:0] dus_req;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   ref_clock_selector #(
      .NPORT(NPORT), .TICK_DIV(4), .ACQ_TICKS(5), .WTR_TICKS(8), .HOLD_TICKS(10)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .line_mode(line_mode), .ref1_port(ref1_port),
      .ref2_port(ref2_port), .ext_valid(ext_valid), .line_valid(line_valid),
      .int_valid(int_valid), .revertive(revertive), .dus_en(dus_en),
      .sel_ref(sel_ref), .sync_state(sync_state), .ev_to_pri(ev_to_pri),
      .ev_to_sec(ev_to_sec), .ev_to_third(ev_to_third), .alm_pri(alm_pri),
      .alm_sec(alm_sec), .alm_third(alm_third), .dus_req(dus_req)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic t_reset();
      step(3);
      chk("R1 sel", sel_ref, 3);
      chk("R1 state", sync_state, 0);
      chk("R1 events", {ev_to_pri, ev_to_sec, ev_to_third}, 0);
      chk("R1 dus", dus_req, 0);
      rst_n = 1'b1;
      step(1);
      chk("R10 start on primary", sel_ref, 1);
      chk("R10 acquire", sync_state, 1);
      chk("R3 ev_to_pri", ev_to_pri, 1);
   endtask

   task automatic t_acquire();
      step(13);
      chk("R8 still acquire", sync_state, 1);
      step(7);
      chk("R8 locked", sync_state, 2);
   endtask

   task automatic t_failover();
      ext_valid = 2'b10;
      step(1);
      chk("R3 to secondary", sel_ref, 2);
      chk("R3 ev_to_sec", ev_to_sec, 1);
      chk("R4 alm_pri set", alm_pri, 1);
      chk("R8 acquire after move", sync_state, 1);
      step(1);
      chk("R3 single pulse", ev_to_sec, 0);
      ext_valid = 2'b00;
      step(1);
      chk("R3 to third", sel_ref, 3);
      chk("R3 ev_to_third", ev_to_third, 1);
      chk("R4 alm_sec set", alm_sec, 1);
   endtask

   task automatic t_revert();
      bit seen = 0;
      ext_valid = 2'b11;
      step(1);
      chk("R4 alm_pri clear", alm_pri, 0);
      chk("R4 alm_sec clear", alm_sec, 0);
      step(24);
      chk("R5 waits before revert", sel_ref, 3);
      for (int i = 0; i < 12; i++) begin
         step(1);
         if (ev_to_pri) seen = 1;
      end
      chk("R5 reverted", sel_ref, 1);
      chk("R5 ev_to_pri seen", seen, 1);
   endtask

   task automatic t_wtr_restart();
      ext_valid = 2'b10;
      step(1);
      chk("R3 to secondary again", sel_ref, 2);
      ext_valid = 2'b11;
      step(20);
      ext_valid = 2'b10;
      step(2);
      chk("R3 stays on valid secondary", sel_ref, 2);
      ext_valid = 2'b11;
      step(26);
      chk("R6 restarted count", sel_ref, 2);
      step(12);
      chk("R6 reverts after full wait", sel_ref, 1);
   endtask

   task automatic t_nonrev();
      revertive = 1'b0;
      ext_valid = 2'b10;
      step(1);
      chk("R7 to secondary", sel_ref, 2);
      ext_valid = 2'b11;
      step(50);
      chk("R7 keeps secondary", sel_ref, 2);
      ext_valid = 2'b01;
      step(1);
      chk("R7 primary on failure", sel_ref, 1);
      chk("R7 ev_to_pri", ev_to_pri, 1);
      revertive = 1'b1;
   endtask

   task automatic t_holdover();
      step(71);
      chk("R8 locked before loss", sync_state, 2);
      ext_valid = 2'b00;
      int_valid = 1'b0;
      step(1);
      chk("R9 sel third", sel_ref, 3);
      chk("R9 holdover", sync_state, 3);
      chk("R4 alm_third", alm_third, 1);
      ext_valid = 2'b01;
      step(1);
      chk("R10 recover primary", sel_ref, 1);
      chk("R10 recover acquire", sync_state, 1);
   endtask

   task automatic t_freerun();
      step(3);
      ext_valid = 2'b00;
      step(1);
      chk("R9 free-run", sync_state, 0);
      chk("R9 free-run sel", sel_ref, 3);
   endtask

   task automatic t_line();
      int_valid  = 1'b1;
      line_mode  = 1'b1;
      ref1_port  = 2'd2;
      ref2_port  = 2'd0;
      line_valid = 4'hF;
      dus_en     = 4'hF;
      ext_valid  = 2'b11;
      step(1);
      chk("R2 line primary", sel_ref, 1);
      chk("R11 dus on port 2", dus_req, 4);
      dus_en = 4'b1011;
      step(1);
      chk("R11 dus disabled", dus_req, 0);
      dus_en     = 4'hF;
      line_valid = 4'b1101;
      ext_valid  = 2'b00;
      step(1);
      chk("R2 unused port ignored", sel_ref, 1);
      chk("R2 no alm_pri", alm_pri, 0);
      chk("R2 no alm_sec", alm_sec, 0);
      line_valid = 4'b1001;
      step(1);
      chk("R2 line secondary", sel_ref, 2);
      chk("R11 dus on port 0", dus_req, 1);
      chk("R4 line alm_pri", alm_pri, 1);
      line_mode = 1'b0;
      ext_valid = 2'b11;
      step(1);
      chk("R2 external secondary kept", sel_ref, 2);
      chk("R11 no dus in external", dus_req, 0);
      chk("R4 ext alm_pri clear", alm_pri, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n      = 1'b0;
      line_mode  = 1'b0;
      ref1_port  = '0;
      ref2_port  = '0;
      ext_valid  = 2'b11;
      line_valid = 4'hF;
      int_valid  = 1'b1;
      revertive  = 1'b1;
      dus_en     = '0;
      t_reset();
      t_acquire();
      t_failover();
      t_revert();
      t_wtr_restart();
      t_nonrev();
      t_holdover();
      t_freerun();
      t_line();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule